// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Realigner

This block sits between a 32-bit instruction fetch port and the decoder. Fetch words arrive aligned, each with its byte address. The instruction stream inside them mixes 16-bit and 32-bit instructions, and any instruction may start on any halfword. The block keeps a small queue of halfword parcels, so a parcel left over from one word can be carried into the next. It hands the decoder one whole instruction per transfer, together with its PC, a length flag and an illegal flag.

The length of each instruction is read from the lowest bits of its first parcel. When those two bits are not `11`, the instruction is a single 16-bit parcel. When they are `11`, it is a 32-bit instruction built from two parcels. When the low five bits are `11111`, the encoding belongs to a longer format. Such an encoding is not assembled: its first parcel is emitted alone and marked illegal.

Both data sides use valid/ready. A fetch word transfers when `fw_valid` and `fw_ready` are both high at a rising clock edge. An instruction transfers when `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, the offered instruction, its PC and its flags stay unchanged. `fw_ready` goes low whenever the queue has fewer than two free halfword slots. A redirect is a plain control input. In its cycle it empties the queue, loads the new PC and suppresses both handshakes.

Top module: `fetch_realigner`

## Requirements
- R1: After reset, `ins_valid` is 0 and `fw_ready` is 1.
- R2: A parcel whose bits [1:0] are not `11` is emitted alone, with `ins_word[15:0]` holding the parcel, `ins_word[31:16]` equal to 0 and `ins_len32` equal to 0.
- R3: A parcel whose bits [1:0] are `11` and whose bits [4:0] are not `11111` is joined with the following parcel. `ins_word` = {second parcel, first parcel} and `ins_len32` = 1. This holds whether the two parcels share one fetch word or span two consecutive words.
- R4: Each emitted instruction carries its own byte address in `ins_pc`. After a 16-bit transfer the next PC is the old PC + 2. After a 32-bit transfer it is the old PC + 4.
- R5: An all-zero 16-bit parcel is emitted as a 16-bit instruction with `ins_illegal` = 1.
- R6: A parcel whose bits [4:0] are `11111` is emitted alone with `ins_illegal` = 1 and `ins_len32` = 0, and the next PC is the old PC + 2. This includes the all-ones parcel 16'hFFFF.
- R7: After a redirect to a PC with bit 1 set, the lower halfword of the first fetched word is dropped. The first instruction emitted has `ins_pc` equal to the redirect PC.
- R8: In a redirect cycle, `ins_valid` and `fw_ready` are both 0. Every queued parcel is discarded, so no instruction queued before the redirect is emitted afterwards.
- R9: The block expects each new fetch word at the next word address in sequence. A word whose `fw_addr` differs from that address is still consumed, but it is dropped and adds nothing to the queue.
- R10: While `ins_valid` is 1 and `ins_ready` is 0, with no redirect, `ins_valid`, `ins_word`, `ins_pc`, `ins_len32` and `ins_illegal` hold their values into the next cycle.
- R11: `fw_ready` is 0 while fewer than two of the queue's halfword slots are free. With the default four slots, after two words have been accepted and nothing has been emitted, no further word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Flush the queue and restart at `redir_pc` |
| redir_pc | input | XLEN | New instruction address (halfword aligned) |
| fw_valid | input | 1 | Fetch word offered |
| fw_ready | output | 1 | Fetch word can be taken |
| fw_word | input | 32 | Fetch word; lower halfword is the lower address |
| fw_addr | input | XLEN | Word-aligned byte address of `fw_word` |
| ins_valid | output | 1 | Instruction offered |
| ins_ready | input | 1 | Decoder takes the instruction |
| ins_word | output | 32 | Instruction bits; upper half zero for single parcels |
| ins_pc | output | XLEN | Byte address of the instruction |
| ins_len32 | output | 1 | 1 for a joined 32-bit instruction |
| ins_illegal | output | 1 | Zero parcel, all-ones parcel or longer-format encoding |

## Verification
In the same cycle, the queue can take a fetch word at its tail and give up one or two parcels at its head. The main stream sweep provokes this by holding `ins_ready` low for one cycle in three while fetch words keep arriving. It then compares every emitted instruction, in order, against a precomputed table, and it also checks that offers stay unchanged while held back. The second collision is a redirect that arrives while the queue is full and an instruction is stalled. In that cycle both handshakes must be low. The first instruction afterwards must come from the new address, and nothing older may follow it.

// File: rtl/rlgn_pkg.sv
package rlgn_pkg;

  localparam int PARCEL_W = 16;

  typedef logic [PARCEL_W-1:0] parcel_t;

  // how the head parcel is to be treated
  typedef enum logic [1:0] {
    PK_SHORT = 2'd0,   // single 16-bit parcel
    PK_FULL  = 2'd1,   // first half of a 32-bit instruction
    PK_LONG  = 2'd2    // start of a longer format, not assembled
  } pkind_e;

endpackage

// File: rtl/rlgn_parcel_class.sv
module rlgn_parcel_class
  import rlgn_pkg::*;
(
  input  parcel_t p,
  output pkind_e  kind,
  output logic    bad
);

  always_comb begin
    if (p[1:0] != 2'b11)
      kind = PK_SHORT;
    else if (p[4:0] == 5'b11111)
      kind = PK_LONG;
    else
      kind = PK_FULL;
  end

  // zero parcel, all-ones parcel, or an unsupported longer encoding
  assign bad = (p == '0) || (p == '1) || (kind == PK_LONG);

endmodule

// File: rtl/rlgn_hw_queue.sv
module rlgn_hw_queue
  import rlgn_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_en,
  input  logic             push_two,
  input  logic [31:0]      push_data,
  input  logic [1:0]       pop_n,
  output parcel_t          head0,
  output parcel_t          head1,
  output logic [CNT_W-1:0] count
);

  parcel_t          slot   [DEPTH];
  parcel_t          slot_n [DEPTH];
  logic [CNT_W-1:0] count_n;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] push_cnt;
  parcel_t          first_in;

  assign first_in = push_two ? push_data[15:0] : push_data[31:16];
  assign push_cnt = push_en ? (push_two ? CNT_W'(2) : CNT_W'(1)) : CNT_W'(0);
  assign base     = count - CNT_W'(pop_n);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH)
        slot_n[i] = slot[i + int'(pop_n)];
      else
        slot_n[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_en && (i == int'(base)))
        slot_n[i] = first_in;
      if (push_en && push_two && (i == int'(base) + 1))
        slot_n[i] = push_data[31:16];
    end
    count_n = base + push_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      count <= count_n;
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_n[i];
    end
  end

  assign head0 = slot[0];
  assign head1 = slot[1];

endmodule

// File: rtl/rlgn_fetch_track.sv
module rlgn_fetch_track #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] START_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir,
  input  logic [XLEN-1:0] redir_pc,
  input  logic            space_ok,
  input  logic            fw_valid,
  input  logic [XLEN-1:0] fw_addr,
  output logic            fw_ready,
  output logic            push_en,
  output logic            push_two
);

  logic [XLEN-1:0] want_addr;
  logic            skip_low;
  logic [XLEN-1:0] word_mask;

  assign word_mask = ~XLEN'(3);
  assign fw_ready  = space_ok && !redir;
  assign push_en   = fw_valid && fw_ready && (fw_addr == want_addr);
  assign push_two  = !skip_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_addr <= START_PC & word_mask;
      skip_low  <= START_PC[1];
    end else if (redir) begin
      want_addr <= redir_pc & word_mask;
      skip_low  <= redir_pc[1];
    end else if (push_en) begin
      want_addr <= want_addr + XLEN'(4);
      skip_low  <= 1'b0;
    end
  end

endmodule

// File: rtl/fetch_realigner.sv
module fetch_realigner
  import rlgn_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DEPTH = 4,
  parameter logic [XLEN-1:0] START_PC = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir_valid,
  input  logic [XLEN-1:0] redir_pc,
  input  logic            fw_valid,
  output logic            fw_ready,
  input  logic [31:0]     fw_word,
  input  logic [XLEN-1:0] fw_addr,
  output logic            ins_valid,
  input  logic            ins_ready,
  output logic [31:0]     ins_word,
  output logic [XLEN-1:0] ins_pc,
  output logic            ins_len32,
  output logic            ins_illegal
);

  parcel_t          head0, head1;
  logic [CNT_W-1:0] count;
  logic             push_en, push_two, space_ok;
  pkind_e           kind;
  logic             bad;
  logic             emit_ok, fire;
  logic [1:0]       pop_n;
  logic [XLEN-1:0]  pc_q;

  rlgn_hw_queue #(.DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (redir_valid),
    .push_en   (push_en),
    .push_two  (push_two),
    .push_data (fw_word),
    .pop_n     (pop_n),
    .head0     (head0),
    .head1     (head1),
    .count     (count)
  );

  rlgn_fetch_track #(.XLEN(XLEN), .START_PC(START_PC)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .redir    (redir_valid),
    .redir_pc (redir_pc),
    .space_ok (space_ok),
    .fw_valid (fw_valid),
    .fw_addr  (fw_addr),
    .fw_ready (fw_ready),
    .push_en  (push_en),
    .push_two (push_two)
  );

  rlgn_parcel_class u_class (
    .p    (head0),
    .kind (kind),
    .bad  (bad)
  );

  assign space_ok = (count <= CNT_W'(DEPTH - 2));

  // a 32-bit instruction waits for its second parcel
  assign emit_ok = (count != '0) &&
                   ((kind != PK_FULL) || (count >= CNT_W'(2)));

  assign ins_valid   = emit_ok && !redir_valid;
  assign ins_len32   = (kind == PK_FULL);
  assign ins_word    = ins_len32 ? {head1, head0} : {16'h0000, head0};
  assign ins_illegal = bad;
  assign ins_pc      = pc_q;

  assign fire  = ins_valid && ins_ready;
  assign pop_n = fire ? (ins_len32 ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= START_PC & ~XLEN'(1);
    else if (redir_valid)
      pc_q <= redir_pc & ~XLEN'(1);
    else
      pc_q <= pc_q + (XLEN'(pop_n) << 1);
  end

endmodule

// File: rtl/rlgn_checks.sv
module rlgn_checks #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redir_valid,
  input logic            fw_ready,
  input logic            ins_valid,
  input logic            ins_ready,
  input logic [31:0]     ins_word,
  input logic [XLEN-1:0] ins_pc,
  input logic            ins_len32,
  input logic            ins_illegal
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> (redir_valid ||
      (ins_valid && $stable(ins_word) && $stable(ins_pc) &&
       $stable(ins_len32) && $stable(ins_illegal))));

  p_redir_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!ins_valid && !fw_ready));

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> (!ins_valid ||
      ins_pc == $past(ins_pc) + ($past(ins_len32) ? XLEN'(4) : XLEN'(2))));

  p_zero_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[15:0] == 16'h0000) |-> ins_illegal);

  p_short_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[1:0] != 2'b11) |-> (!ins_len32 && ins_word[31:16] == 16'h0000));

  p_long_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[4:0] == 5'b11111) |-> (ins_illegal && !ins_len32));

endmodule

bind fetch_realigner rlgn_checks #(.XLEN(XLEN)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .redir_valid (redir_valid),
  .fw_ready    (fw_ready),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .ins_word    (ins_word),
  .ins_pc      (ins_pc),
  .ins_len32   (ins_len32),
  .ins_illegal (ins_illegal)
);

// File: tb/test_fetch_realigner.sv
`timescale 1ns/1ps
module test_fetch_realigner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic        fw_valid = 1'b0;
  logic        fw_ready;
  logic [31:0] fw_word = '0;
  logic [31:0] fw_addr = '0;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [31:0] ins_word;
  logic [31:0] ins_pc;
  logic        ins_len32;
  logic        ins_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_realigner i_fetch_realigner (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_word(fw_word), .fw_addr(fw_addr),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
    .ins_pc(ins_pc), .ins_len32(ins_len32), .ins_illegal(ins_illegal)
  );

  // program image: words at 0x100 .. 0x11C
  localparam logic [31:0] PROG [8] = '{
    32'h8593_4501, 32'h0000_00A5, 32'h007F_4581, 32'h0010_0093,
    32'h8082_FFFF, 32'h0000_0297, 32'h0001_1141, 32'h0105_0E13
  };

  // expected stream from 0x100: {pc, word, len32, illegal}
  localparam logic [65:0] EXP [12] = '{
    {32'h100, 32'h0000_4501, 1'b0, 1'b0},
    {32'h102, 32'h00A5_8593, 1'b1, 1'b0},
    {32'h106, 32'h0000_0000, 1'b0, 1'b1},
    {32'h108, 32'h0000_4581, 1'b0, 1'b0},
    {32'h10A, 32'h0000_007F, 1'b0, 1'b1},
    {32'h10C, 32'h0010_0093, 1'b1, 1'b0},
    {32'h110, 32'h0000_FFFF, 1'b0, 1'b1},
    {32'h112, 32'h0000_8082, 1'b0, 1'b0},
    {32'h114, 32'h0000_0297, 1'b1, 1'b0},
    {32'h118, 32'h0000_1141, 1'b0, 1'b0},
    {32'h11A, 32'h0000_0001, 1'b0, 1'b0},
    {32'h11C, 32'h0105_0E13, 1'b1, 1'b0}
  };

  logic [65:0] got [16];
  int got_n;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return PROG[(a - 32'h100) >> 2];
  endfunction

  function automatic string tag_of(input logic [65:0] e);
    if (e[1]) return "R3";
    if (e[0] && e[17:2] == 16'h0000) return "R5";
    if (e[0]) return "R6";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic redirect(input logic [31:0] pc);
    @(negedge clk);
    redir_valid = 1'b1;
    redir_pc = pc;
    fw_valid = 1'b0;
    #1;
    chk(!ins_valid && !fw_ready, "R8", {64'h0, ins_valid, fw_ready}, 66'h0);
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  // feeds words from 'start', optionally preceded by a stray word, records outputs
  task automatic run_stream(input logic [31:0] start, input bit stray, input int cycles, input bit throttle);
    logic [31:0] a;
    bit stray_left;
    bit held;
    logic [65:0] held_val;
    a = start & ~32'h3;
    stray_left = stray;
    held = 0;
    held_val = '0;
    got_n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (stray_left) begin
        fw_valid = 1'b1; fw_addr = 32'h200; fw_word = 32'h0000_0000;
      end else if (a <= 32'h11C) begin
        fw_valid = 1'b1; fw_addr = a; fw_word = mem_word(a);
      end else begin
        fw_valid = 1'b0;
      end
      ins_ready = throttle ? ((c % 3) != 1) : 1'b1;
      #1;
      if (held)
        chk(ins_valid && {ins_pc, ins_word, ins_len32, ins_illegal} == held_val, "R10",
            {ins_pc, ins_word, ins_len32, ins_illegal}, held_val);
      if (ins_valid && ins_ready && got_n < 16) begin
        got[got_n] = {ins_pc, ins_word, ins_len32, ins_illegal};
        got_n++;
      end
      held = ins_valid && !ins_ready;
      held_val = {ins_pc, ins_word, ins_len32, ins_illegal};
      if (fw_valid && fw_ready) begin
        if (stray_left) stray_left = 0;
        else a = a + 32'h4;
      end
    end
    @(negedge clk);
    fw_valid = 1'b0;
    ins_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!ins_valid, "R1", {65'h0, ins_valid}, 66'h0);
    chk(fw_ready, "R1", {65'h0, fw_ready}, 66'h1);

    // table walk with a stray word first (R9) and back-pressure
    redirect(32'h100);
    run_stream(32'h100, 1'b1, 60, 1'b1);
    chk(got_n == 12, "R9", 66'(got_n), 66'd12);
    for (int k = 0; k < 12; k++) begin
      chk(got[k][65:34] == EXP[k][65:34], "R4", got[k], EXP[k]);
      chk(got[k][33:0] == EXP[k][33:0], tag_of(EXP[k]), got[k], EXP[k]);
    end

    // R7: redirect to an odd-halfword PC
    redirect(32'h10A);
    run_stream(32'h10A, 1'b0, 30, 1'b0);
    chk(got_n >= 2 && got[0] == {32'h10A, 32'h0000_007F, 1'b0, 1'b1}, "R7", got[0],
        {32'h10A, 32'h0000_007F, 1'b0, 1'b1});
    chk(got[1] == {32'h10C, 32'h0010_0093, 1'b1, 1'b0}, "R7", got[1],
        {32'h10C, 32'h0010_0093, 1'b1, 1'b0});

    // R11: fill the queue with the decoder stalled
    redirect(32'h100);
    a = 32'h100;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      ins_ready = 1'b0;
      fw_valid = 1'b1; fw_addr = a; fw_word = mem_word(a);
      #1;
      if (fw_valid && fw_ready) a = a + 32'h4;
    end
    chk(a == 32'h108, "R11", 66'(a), 66'h108);
    chk(!fw_ready, "R11", {65'h0, fw_ready}, 66'h0);
    chk(ins_valid && ins_word == 32'h0000_4501, "R10", {33'h0, ins_valid, ins_word}, {33'h1, 32'h4501});

    // R8: redirect while full and stalled, then nothing old may appear
    redirect(32'h118);
    run_stream(32'h118, 1'b0, 20, 1'b0);
    chk(got_n == 3, "R8", 66'(got_n), 66'd3);
    chk(got[0] == {32'h118, 32'h0000_1141, 1'b0, 1'b0}, "R8", got[0],
        {32'h118, 32'h0000_1141, 1'b0, 1'b0});
    chk(got[2] == {32'h11C, 32'h0105_0E13, 1'b1, 1'b0}, "R3", got[2],
        {32'h11C, 32'h0105_0E13, 1'b1, 1'b0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule